// File: doc/BRIEF.md
# Streaming Connected-Region Labeler

This block labels the foreground of a binary image in one raster pass. Pixels enter one per handshake, left to right and top to bottom. Each pixel leaves one cycle later with a provisional region number, where 0 means background. Connectivity is 8-way. Each decision looks only at the causal window: the left pixel, plus the upper-left, upper and upper-right pixels of the previous line. A line buffer holds the previous line's labels.

When two regions that were opened separately turn out to touch, the block stalls its input for a few cycles. In that time it walks both labels to their roots and links the larger root under the smaller one. Every label also keeps a pixel counter, which serves as that region's work cost.

When the last pixel of a frame has been accepted, a resolve pass runs over the label table in ascending order. It points every entry straight at its smallest equivalent label and folds each non-root count into its root's count. A one-cycle done pulse marks the end of the pass. After that a query port returns, for any allocated label, its root and its region cost, ready to feed a load distributor.

Top module: `ccl_labeler`

## Requirements
- R1: After reset, in_ready is high and out_valid, done and overflow are low.
- R2: Every accepted pixel yields exactly one out_valid cycle, one clock after acceptance, carrying its label; a background pixel (in_pix=0) always gets label 0.
- R3: A foreground pixel with no labelled pixel among its left, upper-left, upper and upper-right neighbours opens a new region with the next unused label; numbering restarts at 1 on each pixel accepted with in_sof=1.
- R4: Neighbours are 8-connected: a pixel touching a labelled pixel only diagonally takes that pixel's label.
- R5: When the window holds two different labels, the pixel gets the smaller one and the two are recorded as equivalent; in_ready is low while the merge is carried out, and a merge whose roots lie deeper in the table is still resolved correctly.
- R6: Neighbours outside the frame read as background: nothing above the first line of a frame (whatever an earlier frame left in the line buffer), nothing left of column 0, and nothing at or past the previous line's width, so no wrap from the line end to the next line start.
- R7: At most MAX_LBL (200) labels are handed out per frame; a further new region gets label 0 and sets overflow, which stays high until the next in_sof pixel is accepted.
- R8: After the pixel marked in_eof is accepted, in_ready stays low through the resolve pass, which ends with done high for exactly one cycle; after that, q_root for every allocated label is the smallest label equivalent to it.
- R9: After done, q_cnt of a root label equals the number of pixels in its whole region, and q_cnt of a non-root label is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel can be accepted this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of its line |
| in_eof | input | 1 | Pixel is the last of the frame |
| in_pix | input | 1 | 1 = foreground, 0 = background |
| out_valid | output | 1 | Label output valid |
| out_label | output | LBL_W (8) | Provisional label of the pixel, 0 = background |
| overflow | output | 1 | Label table ran out in this frame |
| done | output | 1 | One-cycle pulse at the end of the resolve pass |
| q_lbl | input | LBL_W (8) | Label to query |
| q_root | output | LBL_W (8) | Root entry of the queried label |
| q_cnt | output | CNT_W (17) | Pixel count of the queried label |

## Verification
A wrong line-buffer or window state shows up at once, on the next pixel's out_label: a fresh label where an existing one was expected, or a stale label taken from an earlier line or frame. A lost or wrong merge does not change any output label; it becomes visible only after done, as a wrong q_root and a split q_cnt. The bench therefore checks, on each shape, both the per-pixel labels and the resolved roots and costs. A broken stall shows up as a pixel whose label comes from an unfinished table.

// File: rtl/ccl_pkg.sv
package ccl_pkg;
  typedef enum logic [1:0] {
    S_RUN     = 2'd0,
    S_UNION   = 2'd1,
    S_RESOLVE = 2'd2
  } ccl_state_e;
endpackage

// File: rtl/ccl_linebuf.sv
module ccl_linebuf #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [DW-1:0] rdata0,
  output logic [DW-1:0] rdata1
);
  logic [DW-1:0] mem [DEPTH];

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/ccl_window.sv
module ccl_window #(
  parameter int LBL_W = 8
) (
  input  logic [LBL_W-1:0] nb_l,
  input  logic [LBL_W-1:0] nb_ul,
  input  logic [LBL_W-1:0] nb_u,
  input  logic [LBL_W-1:0] nb_ur,
  output logic             is_new,
  output logic             merge,
  output logic [LBL_W-1:0] pick,
  output logic [LBL_W-1:0] side_a,
  output logic [LBL_W-1:0] side_b
);
  // Left and upper-left are already equivalent when both are set;
  // the same holds for upper and upper-right, and for left and upper.
  always_comb begin
    side_a = (nb_l != '0) ? nb_l : nb_ul;
    side_b = (nb_u != '0) ? nb_u : nb_ur;
    is_new = (side_a == '0) && (side_b == '0);
    if (side_a == '0)      pick = side_b;
    else if (side_b == '0) pick = side_a;
    else                   pick = (side_a < side_b) ? side_a : side_b;
    merge = (side_a != '0) && (side_b != '0) && (side_a != side_b) && (nb_u == '0);
  end
endmodule

// File: rtl/ccl_eqtable.sv
module ccl_eqtable #(
  parameter int LBL_W = 8,
  parameter int CNT_W = 17,
  localparam int NENT = 2 ** LBL_W
) (
  input  logic             clk,
  input  logic             alloc_en,
  input  logic [LBL_W-1:0] alloc_lbl,
  input  logic             inc_en,
  input  logic [LBL_W-1:0] inc_lbl,
  input  logic             link_en,
  input  logic [LBL_W-1:0] link_child,
  input  logic [LBL_W-1:0] link_root,
  input  logic             rsv_en,
  input  logic [LBL_W-1:0] rsv_idx,
  input  logic [LBL_W-1:0] fa_idx,
  output logic [LBL_W-1:0] fa_par,
  input  logic [LBL_W-1:0] fb_idx,
  output logic [LBL_W-1:0] fb_par,
  input  logic [LBL_W-1:0] q_idx,
  output logic [LBL_W-1:0] q_par,
  output logic [CNT_W-1:0] q_cnt
);
  logic [LBL_W-1:0] par [NENT];
  logic [CNT_W-1:0] cnt [NENT];
  logic [LBL_W-1:0] rsv_p, rsv_r;

  assign fa_par = par[fa_idx];
  assign fb_par = par[fb_idx];
  assign q_par  = par[q_idx];
  assign q_cnt  = cnt[q_idx];
  // Entries below rsv_idx are final, so two hops reach the root.
  assign rsv_p  = par[rsv_idx];
  assign rsv_r  = par[rsv_p];

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      par[alloc_lbl] <= alloc_lbl;
      cnt[alloc_lbl] <= CNT_W'(1);
    end
    if (inc_en) cnt[inc_lbl] <= cnt[inc_lbl] + CNT_W'(1);
    if (link_en) par[link_child] <= link_root;
    if (rsv_en) begin
      par[rsv_idx] <= rsv_r;
      if (rsv_r != rsv_idx) begin
        cnt[rsv_r]   <= cnt[rsv_r] + cnt[rsv_idx];
        cnt[rsv_idx] <= '0;
      end
    end
  end
endmodule

// File: rtl/ccl_labeler.sv
module ccl_labeler #(
  parameter int W_MAX   = 256,
  parameter int H_MAX   = 256,
  parameter int MAX_LBL = 200,
  parameter int LBL_W   = 8,
  parameter int CNT_W   = $clog2(W_MAX * H_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic             in_eof,
  input  logic             in_pix,
  output logic             out_valid,
  output logic [LBL_W-1:0] out_label,
  output logic             overflow,
  output logic             done,
  input  logic [LBL_W-1:0] q_lbl,
  output logic [LBL_W-1:0] q_root,
  output logic [CNT_W-1:0] q_cnt
);
  import ccl_pkg::*;

  localparam int X_W = $clog2(W_MAX);
  localparam logic [LBL_W-1:0] MAXL = LBL_W'(MAX_LBL);
  localparam logic [LBL_W-1:0] ONE  = LBL_W'(1);

  // reset synchronizer
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // state
  ccl_state_e       st_q, st_d;
  logic [X_W-1:0]   x_q, x_d;
  logic [X_W:0]     pw_q, pw_d;
  logic             first_q, first_d;
  logic [LBL_W-1:0] left_q, left_d, ul_q, ul_d;
  logic [LBL_W-1:0] next_q, next_d;
  logic             ovf_q, ovf_d;
  logic [LBL_W-1:0] ra_q, ra_d, rb_q, rb_d, ridx_q, ridx_d;
  logic             eof_q, eof_d;
  logic             ov_q;
  logic [LBL_W-1:0] ol_q;

  // datapath
  logic             accept, fr;
  logic [X_W-1:0]   xe, xe_p1;
  logic [LBL_W-1:0] nl, u_raw, ur_raw, u_m, ur_m, l_m, ul_m, lbl;
  logic             w_new, w_merge;
  logic [LBL_W-1:0] w_pick, w_a, w_b;
  logic             alloc_en, inc_en, ovf_hit, link_en, rsv_en;
  logic [LBL_W-1:0] fa_par, fb_par, link_child, link_root;

  assign in_ready = srst_n && (st_q == S_RUN);
  assign accept   = in_valid && in_ready;
  assign xe       = in_sof ? '0 : x_q;
  assign xe_p1    = xe + X_W'(1);
  assign fr       = in_sof || first_q;
  assign nl       = in_sof ? ONE : next_q;

  ccl_linebuf #(.DEPTH(W_MAX), .DW(LBL_W)) i_lb (
    .clk(clk), .we(accept), .waddr(xe), .wdata(lbl),
    .raddr0(xe), .raddr1(xe_p1), .rdata0(u_raw), .rdata1(ur_raw)
  );

  always_comb begin
    u_m  = (fr || ({1'b0, xe} >= pw_q)) ? '0 : u_raw;
    ur_m = (fr || (({1'b0, xe} + (X_W+1)'(1)) >= pw_q)) ? '0 : ur_raw;
    l_m  = (xe == '0) ? '0 : left_q;
    ul_m = (xe == '0) ? '0 : ul_q;
  end

  ccl_window #(.LBL_W(LBL_W)) i_win (
    .nb_l(l_m), .nb_ul(ul_m), .nb_u(u_m), .nb_ur(ur_m),
    .is_new(w_new), .merge(w_merge), .pick(w_pick), .side_a(w_a), .side_b(w_b)
  );

  always_comb begin
    alloc_en = accept && in_pix && w_new && (nl <= MAXL);
    ovf_hit  = accept && in_pix && w_new && (nl > MAXL);
    inc_en   = accept && in_pix && !w_new;
    if (!in_pix)     lbl = '0;
    else if (w_new)  lbl = (nl <= MAXL) ? nl : '0;
    else             lbl = w_pick;
  end

  ccl_eqtable #(.LBL_W(LBL_W), .CNT_W(CNT_W)) i_eq (
    .clk(clk),
    .alloc_en(alloc_en), .alloc_lbl(nl),
    .inc_en(inc_en), .inc_lbl(w_pick),
    .link_en(link_en), .link_child(link_child), .link_root(link_root),
    .rsv_en(rsv_en), .rsv_idx(ridx_q),
    .fa_idx(ra_q), .fa_par(fa_par), .fb_idx(rb_q), .fb_par(fb_par),
    .q_idx(q_lbl), .q_par(q_root), .q_cnt(q_cnt)
  );

  assign link_child = (ra_q > rb_q) ? ra_q : rb_q;
  assign link_root  = (ra_q > rb_q) ? rb_q : ra_q;

  // next state
  always_comb begin
    x_d = x_q; pw_d = pw_q; first_d = first_q; left_d = left_q; ul_d = ul_q;
    next_d = next_q; ovf_d = ovf_q;
    st_d = st_q; ra_d = ra_q; rb_d = rb_q; eof_d = eof_q; ridx_d = ridx_q;
    link_en = 1'b0; rsv_en = 1'b0; done = 1'b0;
    if (accept) begin
      x_d     = in_eol ? '0 : xe_p1;
      first_d = fr && !in_eol;
      if (in_eol) pw_d = {1'b0, xe} + (X_W+1)'(1);
      left_d  = lbl;
      ul_d    = u_m;
      next_d  = alloc_en ? nl + ONE : nl;
      ovf_d   = (in_sof ? 1'b0 : ovf_q) | ovf_hit;
    end
    unique case (st_q)
      S_RUN: begin
        if (accept) begin
          if (in_pix && w_merge) begin
            st_d = S_UNION; ra_d = w_a; rb_d = w_b; eof_d = in_eof;
          end else if (in_eof) begin
            st_d = S_RESOLVE; ridx_d = ONE;
          end
        end
      end
      S_UNION: begin
        if ((fa_par == ra_q) && (fb_par == rb_q)) begin
          link_en = (ra_q != rb_q);
          if (eof_q) begin st_d = S_RESOLVE; ridx_d = ONE; end
          else       st_d = S_RUN;
        end else begin
          ra_d = fa_par; rb_d = fb_par;
        end
      end
      S_RESOLVE: begin
        if (ridx_q < next_q) begin
          rsv_en = 1'b1; ridx_d = ridx_q + ONE;
        end else begin
          done = 1'b1; st_d = S_RUN;
        end
      end
      default: st_d = S_RUN;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= S_RUN; x_q <= '0; pw_q <= '0; first_q <= 1'b1;
      left_q <= '0; ul_q <= '0; next_q <= ONE; ovf_q <= 1'b0;
      ra_q <= '0; rb_q <= '0; eof_q <= 1'b0; ridx_q <= ONE;
      ov_q <= 1'b0; ol_q <= '0;
    end else begin
      st_q <= st_d; x_q <= x_d; pw_q <= pw_d; first_q <= first_d;
      left_q <= left_d; ul_q <= ul_d; next_q <= next_d; ovf_q <= ovf_d;
      ra_q <= ra_d; rb_q <= rb_d; eof_q <= eof_d; ridx_q <= ridx_d;
      ov_q <= accept;
      if (accept) ol_q <= lbl;
    end
  end

  assign out_valid = ov_q;
  assign out_label = ol_q;
  assign overflow  = ovf_q;
endmodule

// File: rtl/ccl_labeler_chk.sv
module ccl_labeler_chk #(
  parameter int MAX_LBL = 200,
  parameter int LBL_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sof,
  input logic             in_pix,
  input logic             out_valid,
  input logic [LBL_W-1:0] out_label,
  input logic             overflow,
  input logic             done
);
  p_lbl_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_label <= LBL_W'(MAX_LBL)));

  p_out_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready));

  p_bg_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_pix) |=> (out_valid && (out_label == '0)));

  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(in_valid && in_ready && in_sof)) |=> overflow);

  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ccl_labeler ccl_labeler_chk #(.MAX_LBL(MAX_LBL), .LBL_W(LBL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sof(in_sof), .in_pix(in_pix), .out_valid(out_valid),
  .out_label(out_label), .overflow(overflow), .done(done)
);

// File: tb/test_ccl_labeler.sv
module test_ccl_labeler;
  localparam int LBL_W = 8;
  localparam int CNT_W = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, in_eof = 1'b0, in_pix = 1'b0;
  logic in_ready, out_valid, overflow, done;
  logic [LBL_W-1:0] out_label, q_root;
  logic [LBL_W-1:0] q_lbl = '0;
  logic [CNT_W-1:0] q_cnt;

  int checks = 0, errors = 0;
  int lbl_log [1024];
  int nout = 0, done_cnt = 0, stalls = 0;

  always #4 clk = ~clk;

  ccl_labeler i_ccl_labeler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_eol(in_eol), .in_eof(in_eof), .in_pix(in_pix),
    .out_valid(out_valid), .out_label(out_label), .overflow(overflow),
    .done(done), .q_lbl(q_lbl), .q_root(q_root), .q_cnt(q_cnt)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      if (nout < 1024) lbl_log[nout] = int'(out_label);
      nout++;
    end
    if (done) done_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pix_of(input int kind, input int x, input int y);
    case (kind)
      0: return (x == 1) && (y == 1);
      1: return x == y;
      2: return (y == 1) || (x != 1);
      3: return (y == 0) ? (x % 2 == 0) : (x % 2 == 1);
      4: return 1'b1;
      5: return (y == 0) ? (x == 3) : (x == 0);
      6: return (y % 2 == 0) && (x % 2 == 0);
      default: return 1'b0;
    endcase
  endfunction

  task automatic send_px(input bit p, input bit s, input bit l, input bit e);
    @(negedge clk);
    in_valid = 1'b1; in_pix = p; in_sof = s; in_eol = l; in_eof = e;
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input int kind, input int w, input int h);
    nout = 0;
    stalls = 0;
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++)
        send_px(pix_of(kind, x, y), (x == 0) && (y == 0), x == w - 1,
                (x == w - 1) && (y == h - 1));
  endtask

  task automatic wait_done(input int npix);
    int start = done_cnt;
    int n = 0;
    while (done_cnt == start && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check("R8 single done pulse", done_cnt - start, 1);
    check("R2 one output per pixel", nout, npix);
  endtask

  task automatic q_chk(input string req, input int lbl, input int er, input int ec);
    @(negedge clk);
    q_lbl = LBL_W'(lbl);
    #1;
    check({req, " root"}, int'(q_root), er);
    check({req, " cost"}, int'(q_cnt), ec);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 done", int'(done), 0);
    check("R1 overflow", int'(overflow), 0);
  endtask

  task automatic t_single;
    send_frame(0, 3, 3);
    wait_done(9);
    check("R2 background label", lbl_log[0], 0);
    check("R3 first label", lbl_log[4], 1);
    q_chk("R9 single", 1, 1, 1);
  endtask

  task automatic t_diag;
    send_frame(1, 4, 4);
    wait_done(16);
    check("R5 no stall without merge", stalls, 0);
    for (int i = 0; i < 4; i++) check("R4 diagonal label", lbl_log[i * 5], 1);
    check("R2 off-diagonal", lbl_log[1], 0);
    q_chk("R9 diagonal", 1, 1, 4);
  endtask

  task automatic t_ushape;
    send_frame(2, 3, 2);
    wait_done(6);
    check("R3 second label", lbl_log[2], 2);
    check("R5 smaller label", lbl_log[4], 1);
    check("R5 after merge", lbl_log[5], 1);
    check("R5 merge stalls input", int'(stalls > 0), 1);
    q_chk("R8 merged root", 2, 1, 0);
    q_chk("R9 region cost", 1, 1, 5);
  endtask

  task automatic t_chain;
    send_frame(3, 5, 2);
    wait_done(10);
    check("R3 label three", lbl_log[4], 3);
    check("R5 first merge", lbl_log[6], 1);
    check("R5 pick smaller", lbl_log[8], 2);
    q_chk("R8 chain root 2", 2, 1, 0);
    q_chk("R8 chain root 3", 3, 1, 0);
    q_chk("R9 chain cost", 1, 1, 5);
  endtask

  task automatic t_rect;
    int bad = 0;
    send_frame(4, 10, 5);
    wait_done(50);
    for (int i = 0; i < 50; i++) if (lbl_log[i] != 1) bad++;
    check("R3 solid single label", bad, 0);
    q_chk("R9 solid cost", 1, 1, 50);
  endtask

  task automatic t_wrap;
    send_frame(5, 4, 2);
    wait_done(8);
    check("R6 first line ignores old frame", lbl_log[3], 1);
    check("R6 no wrap at line end", lbl_log[4], 2);
  endtask

  task automatic t_overflow;
    send_frame(6, 40, 21);
    wait_done(840);
    check("R3 first of many", lbl_log[0], 1);
    check("R7 last allowed label", lbl_log[758], 200);
    check("R7 excess region gets 0", lbl_log[800], 0);
    check("R7 overflow set", int'(overflow), 1);
    q_chk("R9 last region cost", 200, 200, 1);
  endtask

  task automatic t_blank;
    send_frame(7, 3, 3);
    wait_done(9);
    check("R7 overflow cleared by new frame", int'(overflow), 0);
    check("R2 blank label", lbl_log[4], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_diag();
    t_ushape();
    t_chain();
    t_wrap();
    t_rect();
    t_overflow();
    t_blank();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule